// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file for a processor that gives every active procedure level its own window of registers. The windows are arranged in a circle. A current-window pointer translates each 5-bit architectural register number into a physical register. A call command (save) moves the pointer one step down the circle, and a return command (restore) moves it back one step. Each window has three sections of eight registers: inputs, locals and outputs. The output section of a caller is the same storage as the input section of its callee, so arguments and results cross a call without any copying. Eight global registers are visible from every window.

The register file has two combinational read ports and one write port that takes effect at the clock edge. A small occupancy state machine counts how many windows hold live procedure activations. A save when the circle is full, or a restore when only the base window is live, is refused. The refused command leaves the pointer where it was and raises a one-cycle overflow or underflow flag. Software can then spill windows to memory or fill them back.

Occupancy states: `OCC_BASE` (one live window), `OCC_MID` (two up to NWIN-2 live windows) and `OCC_DEEP` (NWIN-1 live windows, full). Transitions:
- `T_FIRST_CALL`: from BASE to MID on a save.
- `T_FILL_UP`: from MID to DEEP on a save that reaches NWIN-1.
- `T_DRAIN`: from DEEP to MID on a restore.
- `T_LAST_RETURN`: from MID to BASE on a restore that reaches one.

A save in DEEP and a restore in BASE keep the state unchanged and raise a trap flag.

Top module: `regwin_file`

## Requirements
- R1: Architectural numbers split into sections by bits [4:3]: 0 to 7 are globals, 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. A global holds the same value in every window.
- R2: Register 0 always reads as zero on both read ports, and a write to register 0 is discarded.
- R3: A save while NWIN-1 windows are live leaves the pointer and the register mapping unchanged. It sets `overflow` high for exactly the one cycle after the clock edge that took the save.
- R4: A restore while only one window is live leaves the pointer unchanged. It sets `underflow` high for exactly the one cycle after the clock edge that took the restore.
- R5: A save steps the window pointer down by one modulo NWIN, and a restore steps it up by one. After a save, the callee's ins (24 to 31) show the caller's outs (8 to 15). After the matching restore, the caller's outs show what the callee wrote to its ins.
- R6: Locals of adjacent windows are separate storage, so writes made at one level are not visible as locals at the neighbouring level.
- R7: A write issued in the same cycle as a save or restore is placed using the window pointer from before the step.
- R8: The read ports are combinational. A read in the same cycle as a write to the same register returns the old value, and a read in any later cycle returns the new value.
- R9: A save and a restore asserted together are both ignored. The pointer, the occupancy and both flags stay unchanged.
- R10: After reset the pointer is at window 0, one window is live, both flags are low and every register reads zero.
- R11: The pointer wraps from window 0 to window NWIN-1. After NWIN-2 saves and the same number of restores, each level sees its own locals again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Architectural register number for read port A |
| rd_a_data | output | XLEN | Read port A data, combinational |
| rd_b_idx | input | 5 | Architectural register number for read port B |
| rd_b_data | output | XLEN | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Call command: step to a fresh window |
| restore_req | input | 1 | Return command: step back to the caller window |
| overflow | output | 1 | One-cycle pulse when a save is refused because the file is full |
| underflow | output | 1 | One-cycle pulse when a restore is refused at the base window |

## Verification
Read data follows the index and the pointer in the same cycle. Written data, a pointer step and the trap flags all appear after the next rising edge, and a flag drops again one edge later. The bench changes inputs on the falling edge and reads the ports half a nanosecond after that. It checks a flag right after the falling edge that follows the edge which took the command, and checks again one cycle later that the flag has cleared. Same-cycle read-before-write is sampled before the edge, and the new value is sampled at the next falling edge.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    // occupancy of the circular window file
    typedef enum logic [1:0] {
        OCC_BASE = 2'd0,
        OCC_MID  = 2'd1,
        OCC_DEEP = 2'd2
    } occ_state_t;

    // section decoded from architectural register bits [4:3]
    typedef enum logic [1:0] {
        SEC_GLOBAL = 2'd0,
        SEC_OUT    = 2'd1,
        SEC_LOCAL  = 2'd2,
        SEC_IN     = 2'd3
    } reg_section_t;

    localparam int ARCH_W   = 5;
    localparam int SECT_SZ  = 8;
    localparam int WIN_SZ   = 2 * SECT_SZ;

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW   = $clog2(NWIN),
    localparam int CNTW = $clog2(NWIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    output logic [CW-1:0] cwp,
    output logic          ovf,
    output logic          unf
);

    localparam logic [CNTW-1:0] LIVE_MAX = CNTW'(NWIN - 1);

    occ_state_t      state, state_nx;
    logic [CNTW-1:0] live, live_nx;
    logic            do_save, do_rest, save_ok, rest_ok;

    assign do_save = save_req && !restore_req;
    assign do_rest = restore_req && !save_req;
    assign save_ok = do_save && (state != OCC_DEEP);
    assign rest_ok = do_rest && (state != OCC_BASE);

    always_comb begin
        live_nx = live;
        if (save_ok)      live_nx = live + 1'b1;
        else if (rest_ok) live_nx = live - 1'b1;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            OCC_BASE: if (save_ok)                          // T_FIRST_CALL
                state_nx = (live_nx == LIVE_MAX) ? OCC_DEEP : OCC_MID;
            OCC_MID: begin
                if (save_ok && live_nx == LIVE_MAX)         // T_FILL_UP
                    state_nx = OCC_DEEP;
                else if (rest_ok && live_nx == CNTW'(1))    // T_LAST_RETURN
                    state_nx = OCC_BASE;
            end
            OCC_DEEP: if (rest_ok)                          // T_DRAIN
                state_nx = (live_nx == CNTW'(1)) ? OCC_BASE : OCC_MID;
            default: state_nx = OCC_BASE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCC_BASE;
        else        state <= state_nx;
    end

    // outputs: pointer, occupancy, trap flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cwp  <= '0;
            live <= CNTW'(1);
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else begin
            live <= live_nx;
            ovf  <= do_save && (state == OCC_DEEP);
            unf  <= do_rest && (state == OCC_BASE);
            if (save_ok)
                cwp <= (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
            else if (rest_ok)
                cwp <= (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
        end
    end

    assert_hold_on_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_save && state == OCC_DEEP) |=> (cwp == $past(cwp) && ovf));

    assert_hold_on_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rest && state == OCC_BASE) |=> (cwp == $past(cwp) && unf));

    assert_save_steps_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        save_ok |=> (cwp == (($past(cwp) == '0) ? CW'(NWIN - 1) : $past(cwp) - 1'b1)));

    assert_restore_steps_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rest_ok |=> (cwp == (($past(cwp) == CW'(NWIN - 1)) ? '0 : $past(cwp) + 1'b1)));

    assert_both_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> ($stable(cwp) && $stable(state) && !ovf && !unf));

    assert_live_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live >= CNTW'(1)) && (live <= LIVE_MAX));

    assert_state_matches_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_BASE) == (live == CNTW'(1)));

endmodule

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN  = 8,
    localparam int CW    = $clog2(NWIN),
    localparam int NPHYS = SECT_SZ + NWIN * WIN_SZ,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic [ARCH_W-1:0] areg,
    input  logic [CW-1:0]     cwp,
    output logic [PW-1:0]     pidx
);

    reg_section_t sec;
    logic [2:0]   off;
    int           win_up;
    int           flat;

    assign sec = reg_section_t'(areg[4:3]);
    assign off = areg[2:0];

    // caller sits one step up the circle; its outs are our ins
    assign win_up = (int'(cwp) == NWIN - 1) ? 0 : int'(cwp) + 1;

    always_comb begin
        unique case (sec)
            SEC_GLOBAL: flat = int'(off);
            SEC_OUT:    flat = SECT_SZ + int'(cwp) * WIN_SZ + int'(off);
            SEC_LOCAL:  flat = SECT_SZ + int'(cwp) * WIN_SZ + SECT_SZ + int'(off);
            SEC_IN:     flat = SECT_SZ + win_up * WIN_SZ + int'(off);
            default:    flat = 0;
        endcase
    end

    assign pidx = PW'(flat);

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int NPHYS = 136,
    parameter int XLEN  = 32,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   ra_pidx,
    output logic [XLEN-1:0] ra_data,
    input  logic [PW-1:0]   rb_pidx,
    output logic [XLEN-1:0] rb_data,
    input  logic            we,
    input  logic [PW-1:0]   w_pidx,
    input  logic [XLEN-1:0] w_data
);

    logic [XLEN-1:0] mem [NPHYS];

    // physical slot 0 is the hardwired-zero global
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we && w_pidx != '0) begin
            mem[w_pidx] <= w_data;
        end
    end

    assign ra_data = (ra_pidx == '0) ? '0 : mem[ra_pidx];
    assign rb_data = (rb_pidx == '0) ? '0 : mem[rb_pidx];

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    output logic            overflow,
    output logic            underflow
);

    localparam int CW    = $clog2(NWIN);
    localparam int NPHYS = SECT_SZ + NWIN * WIN_SZ;
    localparam int PW    = $clog2(NPHYS);
    localparam int NPORT = 3;

    logic [CW-1:0]     cwp;
    logic [ARCH_W-1:0] a_idx [NPORT];
    logic [PW-1:0]     p_idx [NPORT];

    assign a_idx[0] = rd_a_idx;
    assign a_idx[1] = rd_b_idx;
    assign a_idx[2] = wr_idx;

    regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cwp         (cwp),
        .ovf         (overflow),
        .unf         (underflow)
    );

    // one translator per port; the write port sees the pre-step pointer
    for (genvar g = 0; g < NPORT; g++) begin : g_map
        regwin_map #(.NWIN(NWIN)) u_map (
            .areg (a_idx[g]),
            .cwp  (cwp),
            .pidx (p_idx[g])
        );
    end

    regwin_store #(.NPHYS(NPHYS), .XLEN(XLEN)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_pidx (p_idx[0]),
        .ra_data (rd_a_data),
        .rb_pidx (p_idx[1]),
        .rb_data (rd_b_data),
        .we      (wr_en),
        .w_pidx  (p_idx[2]),
        .w_data  (wr_data)
    );

    assert_zero_reg_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    assert_zero_reg_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));

    assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != 5'd0 && rd_a_idx == wr_idx && !save_req && !restore_req)
        |=> ($stable(rd_a_idx) -> rd_a_data == $past(wr_data)));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

endmodule

// File: tb/tb_regwin_file.sv
`timescale 1ns/100ps
module tb_regwin_file;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic            wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic            overflow, underflow;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    regwin_file #(.NWIN(8), .XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_a(input logic [4:0] idx, output logic [XLEN-1:0] v);
        rd_a_idx = idx;
        #0.5;
        v = rd_a_data;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [XLEN-1:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic r);
        save_req = s; restore_req = r;
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [XLEN-1:0] v;
        chk("R10 overflow after reset", {31'd0, overflow}, 32'd0);
        chk("R10 underflow after reset", {31'd0, underflow}, 32'd0);
        rd_a(5'd17, v); chk("R10 local reads zero", v, 32'd0);
        rd_a(5'd3, v);  chk("R10 global reads zero", v, 32'd0);
    endtask

    task automatic t_zero_reg();
        logic [XLEN-1:0] v;
        wr(5'd0, 32'hFFFF_FFFF);
        rd_a(5'd0, v); chk("R2 r0 port A", v, 32'd0);
        rd_b_idx = 5'd0; #0.5;
        chk("R2 r0 port B", rd_b_data, 32'd0);
    endtask

    task automatic t_overlap();
        logic [XLEN-1:0] v;
        wr(5'd3, 32'hC0DE_0003);
        wr(5'd16, 32'hAAAA_0000);
        wr(5'd8, 32'h0B0B_0008);
        pulse(1'b1, 1'b0);
        chk("R5 save no overflow", {31'd0, overflow}, 32'd0);
        rd_a(5'd24, v); chk("R5 callee in shows caller out", v, 32'h0B0B_0008);
        rd_a(5'd16, v); chk("R6 callee local distinct", v, 32'd0);
        rd_a(5'd3, v);  chk("R1 global seen in callee", v, 32'hC0DE_0003);
        wr(5'd24, 32'h1234_5678);
        wr(5'd16, 32'hBBBB_0001);
        pulse(1'b0, 1'b1);
        chk("R5 restore no underflow", {31'd0, underflow}, 32'd0);
        rd_a(5'd8, v);  chk("R5 caller out shows callee result", v, 32'h1234_5678);
        rd_a(5'd16, v); chk("R6 caller local kept", v, 32'hAAAA_0000);
    endtask

    task automatic t_read_write_timing();
        logic [XLEN-1:0] v;
        wr(5'd17, 32'h0000_1111);
        wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'h0000_2222; rd_a_idx = 5'd17;
        #0.5;
        chk("R8 same-cycle read old", rd_a_data, 32'h0000_1111);
        @(negedge clk);
        wr_en = 1'b0;
        rd_a(5'd17, v); chk("R8 later read new", v, 32'h0000_2222);
    endtask

    task automatic t_write_with_save();
        logic [XLEN-1:0] v;
        wr_en = 1'b1; wr_idx = 5'd18; wr_data = 32'h5EED_0018; save_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; save_req = 1'b0;
        rd_a(5'd18, v); chk("R7 write not in new window", v, 32'd0);
        pulse(1'b0, 1'b1);
        rd_a(5'd18, v); chk("R7 write landed in old window", v, 32'h5EED_0018);
    endtask

    task automatic t_both();
        logic [XLEN-1:0] v;
        pulse(1'b1, 1'b1);
        chk("R9 no overflow", {31'd0, overflow}, 32'd0);
        chk("R9 no underflow", {31'd0, underflow}, 32'd0);
        rd_a(5'd16, v); chk("R9 window unchanged", v, 32'hAAAA_0000);
        pulse(1'b0, 1'b1);
        chk("R9 R4 still at base, restore traps", {31'd0, underflow}, 32'd1);
        @(negedge clk);
        chk("R4 underflow one cycle", {31'd0, underflow}, 32'd0);
        rd_a(5'd16, v); chk("R4 pointer unchanged", v, 32'hAAAA_0000);
    endtask

    task automatic t_deep();
        logic [XLEN-1:0] v;
        wr(5'd16, 32'h0000_0100);
        for (int k = 1; k <= 6; k++) begin
            pulse(1'b1, 1'b0);
            chk("R3 R11 save below full no trap", {31'd0, overflow}, 32'd0);
            wr(5'd16, 32'h0000_0100 + k);
        end
        rd_a(5'd3, v); chk("R1 global at depth", v, 32'hC0DE_0003);
        pulse(1'b1, 1'b0);
        chk("R3 overflow raised", {31'd0, overflow}, 32'd1);
        rd_a(5'd16, v); chk("R3 pointer unchanged", v, 32'h0000_0106);
        @(negedge clk);
        chk("R3 overflow one cycle", {31'd0, overflow}, 32'd0);
        for (int k = 6; k >= 1; k--) begin
            rd_a(5'd16, v); chk("R11 level local restored", v, 32'h0000_0100 + k);
            pulse(1'b0, 1'b1);
            chk("R11 restore no trap", {31'd0, underflow}, 32'd0);
        end
        rd_a(5'd16, v); chk("R11 base local after wrap", v, 32'h0000_0100);
        pulse(1'b0, 1'b1);
        chk("R4 underflow at base", {31'd0, underflow}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_reg();
        t_overlap();
        t_read_write_timing();
        t_write_with_save();
        t_both();
        t_deep();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule